// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block is a small, fully associative store of recent page translations that a memory pipeline consults on every access. Each slot pairs a virtual page number and an 8-bit process tag with a physical page number, a present bit, separate kernel and user permission fields, a cacheable bit, and referenced and dirty flags. A lookup compares the presented page number, together with the current process tag, against every slot in parallel. One cycle after the lookup is accepted, the block reports one of four outcomes: a translation, a miss that asks the walker for a refill, a page fault, or a permission fault.

The process tag lives in a plain control input, so a context switch only changes that input and no entries have to be discarded. Refills arrive on a fill port. A refill goes to the slot that already holds the same page and tag, or to the lowest empty slot, or else to a victim picked by a 15-bit tree pseudo-LRU. Single entries can be dropped when a page table entry changes, and a flush input empties the whole buffer.

The lookup and fill ports use valid/ready handshakes. Flush and invalidate take priority over both and hold both ready signals low. A pending fill holds the lookup ready low. The response is a one-cycle pulse with no back-pressure, so the consumer must take it in the cycle it appears.

Top module: `ptlb_top`

## Requirements
- R1: A lookup hits only a slot that is occupied, has an equal virtual page number and has a process tag equal to `cur_pid`. A hit with permission returns `rsp_hit` with that slot's physical page and cacheable bit, on the cycle after the request is accepted.
- R2: A lookup with no matching slot returns `rsp_miss`, which is the refill request, and leaves every slot unchanged.
- R3: A lookup that matches a slot whose present bit is 0 returns `rsp_pfault` instead of a translation. This takes precedence over the permission check.
- R4: Permissions are 2-bit fields: 00 means no access, 01 means read only, and 10 or 11 mean read and write. The kernel field applies when `req_user` is 0 and the user field applies when it is 1. A denied access to a present page returns `rsp_afault`, which is separate from a miss.
- R5: A permitted hit sets the slot's referenced flag, and a permitted write hit also sets its dirty flag. `rsp_ref` and `rsp_dirty` show the flags after this update. Misses and faults leave the flags unchanged, and a fill clears both flags.
- R6: A fill overwrites the slot holding the same page and tag if there is one. Otherwise it uses the lowest-numbered empty slot. Only when all slots are occupied does it use the pseudo-LRU victim. Two slots never match the same key.
- R7: Pseudo-LRU uses a binary tree with nodes 1..15 (children 2n and 2n+1). Node bit 0 points left (lower slots) and 1 points right. A permitted hit or a fill sets each node on that slot's path to point away from it, and the victim is found by following the node bits from the root.
- R8: `inval_en` drops only the slot whose page and tag equal `inval_vpn` and `inval_pid`. Other slots are unaffected.
- R9: `flush_all` empties every slot, and subsequent lookups miss.
- R10: Changing `cur_pid` makes slots of other tags miss without removing them. Restoring the tag makes them hit again.
- R11: Priority is flush > invalidate > fill > lookup. `fill_ready` is low during flush or invalidate. `req_ready` is also low while `fill_valid` is high. A response appears only after an accepted request.
- R12: Every response asserts exactly one of `rsp_hit`, `rsp_miss`, `rsp_pfault` and `rsp_afault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pid | input | 8 | Current process tag |
| flush_all | input | 1 | Empty all slots |
| inval_en | input | 1 | Drop one slot |
| inval_vpn | input | 20 | Page of slot to drop |
| inval_pid | input | 8 | Tag of slot to drop |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_vpn | input | 20 | Lookup virtual page |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Translation delivered |
| rsp_miss | output | 1 | No match; refill request |
| rsp_pfault | output | 1 | Matched page not present |
| rsp_afault | output | 1 | Access denied |
| rsp_ppn | output | 20 | Physical page on hit |
| rsp_cache | output | 1 | Cacheable bit on hit |
| rsp_ref | output | 1 | Referenced flag after update |
| rsp_dirty | output | 1 | Dirty flag after update |
| fill_valid | input | 1 | Refill entry valid |
| fill_ready | output | 1 | Refill entry accepted |
| fill_vpn | input | 20 | Refill virtual page |
| fill_pid | input | 8 | Refill process tag |
| fill_ppn | input | 20 | Refill physical page |
| fill_present | input | 1 | Refill present bit |
| fill_kperm | input | 2 | Refill kernel permission |
| fill_uperm | input | 2 | Refill user permission |
| fill_cache | input | 1 | Refill cacheable bit |

## Verification
A corrupted slot field shows up at the ports on the first lookup of that page: a wrong page number, a wrong outcome, or stale referenced and dirty flags. A wrong pseudo-LRU tree stays hidden until the buffer is full and a refill evicts a slot. It then shows as a miss on the page that should have survived, and a hit on the page that should have gone. The bench therefore sweeps every resident page after each eviction. A slot left behind by invalidation or flush shows as a hit where a miss is expected, on the very next lookup of that key.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  localparam int TLB_SLOTS  = 16;
  localparam int TLB_VPN_W  = 20;
  localparam int TLB_PPN_W  = 20;
  localparam int TLB_PID_W  = 8;

  // permission encodings: 00 none, 01 read only, 1x read/write
  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RO   = 2'b01;
  localparam logic [1:0] PERM_RW   = 2'b10;

  function automatic logic perm_allows(input logic [1:0] perm, input logic is_write);
    return (perm != PERM_NONE) && (!is_write || perm[1]);
  endfunction
endpackage

// File: rtl/ptlb_match.sv
module ptlb_match #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N-1:0]               slot_used,
  input  logic [N-1:0][VPN_W-1:0]    slot_vpn,
  input  logic [N-1:0][PID_W-1:0]    slot_pid,
  input  logic [VPN_W-1:0]           key_vpn,
  input  logic [PID_W-1:0]           key_pid,
  output logic                       found,
  output logic [IDX_W-1:0]           found_idx
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = slot_used[g] && (slot_vpn[g] == key_vpn) && (slot_pid[g] == key_pid);
  end

  always_comb begin
    found_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) found_idx = IDX_W'(i);
    end
  end

  assign found = |hit_vec;

  // R6
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
endmodule

// File: rtl/ptlb_plru.sv
module ptlb_plru #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim
);
  logic [N-1:1] tree, tree_nxt;

  always_comb begin
    int node;
    tree_nxt = tree;
    node = 1;
    for (int l = 0; l < IDX_W; l++) begin
      tree_nxt[node] = ~touch_idx[IDX_W-1-l];
      node = node * 2 + int'(touch_idx[IDX_W-1-l]);
    end
  end

  always_comb begin
    int node;
    node = 1;
    for (int l = 0; l < IDX_W; l++) begin
      node = node * 2 + int'(tree[node]);
    end
    victim = IDX_W'(node - N);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tree <= '0;
    else if (touch_en) tree <= tree_nxt;
  end

  // R7
  victim_not_recent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(touch_en) |-> (victim != $past(touch_idx)));
endmodule

// File: rtl/ptlb_top.sv
module ptlb_top #(
  parameter int N     = ptlb_pkg::TLB_SLOTS,
  parameter int VPN_W = ptlb_pkg::TLB_VPN_W,
  parameter int PPN_W = ptlb_pkg::TLB_PPN_W,
  parameter int PID_W = ptlb_pkg::TLB_PID_W,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PID_W-1:0] cur_pid,
  input  logic             flush_all,
  input  logic             inval_en,
  input  logic [VPN_W-1:0] inval_vpn,
  input  logic [PID_W-1:0] inval_pid,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_write,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_pfault,
  output logic             rsp_afault,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             rsp_cache,
  output logic             rsp_ref,
  output logic             rsp_dirty,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_present,
  input  logic [1:0]       fill_kperm,
  input  logic [1:0]       fill_uperm,
  input  logic             fill_cache
);
  import ptlb_pkg::*;

  logic [N-1:0]              used, refd, dirty, present, cacheable;
  logic [N-1:0][VPN_W-1:0]   vpn_q;
  logic [N-1:0][PID_W-1:0]   pid_q;
  logic [N-1:0][PPN_W-1:0]   ppn_q;
  logic [N-1:0][1:0]         kperm_q, uperm_q;

  logic             lk_found, fm_found, im_found;
  logic [IDX_W-1:0] lk_idx, fm_idx, im_idx, free_idx, victim, fill_tgt;
  logic             lk_go, fill_go, lk_ok, lk_good;
  logic [1:0]       lk_perm;

  assign fill_ready = !flush_all && !inval_en;
  assign req_ready  = fill_ready && !fill_valid;
  assign lk_go      = req_valid && req_ready;
  assign fill_go    = fill_valid && fill_ready;

  ptlb_match #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_match (
    .clk(clk), .rst_n(rst_n), .slot_used(used), .slot_vpn(vpn_q), .slot_pid(pid_q),
    .key_vpn(req_vpn), .key_pid(cur_pid), .found(lk_found), .found_idx(lk_idx));

  ptlb_match #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_fill_match (
    .clk(clk), .rst_n(rst_n), .slot_used(used), .slot_vpn(vpn_q), .slot_pid(pid_q),
    .key_vpn(fill_vpn), .key_pid(fill_pid), .found(fm_found), .found_idx(fm_idx));

  ptlb_match #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_inval_match (
    .clk(clk), .rst_n(rst_n), .slot_used(used), .slot_vpn(vpn_q), .slot_pid(pid_q),
    .key_vpn(inval_vpn), .key_pid(inval_pid), .found(im_found), .found_idx(im_idx));

  ptlb_plru #(.N(N)) u_plru (
    .clk(clk), .rst_n(rst_n),
    .touch_en((lk_go && lk_good) || fill_go),
    .touch_idx(fill_go ? fill_tgt : lk_idx),
    .victim(victim));

  // lowest empty slot
  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used[i]) free_idx = IDX_W'(i);
    end
  end

  assign fill_tgt = fm_found ? fm_idx : (!(&used) ? free_idx : victim);
  assign lk_perm  = req_user ? uperm_q[lk_idx] : kperm_q[lk_idx];
  assign lk_ok    = perm_allows(lk_perm, req_write);
  assign lk_good  = lk_found && present[lk_idx] && lk_ok;

  // slot payload (no reset needed; guarded by used)
  always_ff @(posedge clk) begin
    if (fill_go) begin
      vpn_q[fill_tgt]     <= fill_vpn;
      pid_q[fill_tgt]     <= fill_pid;
      ppn_q[fill_tgt]     <= fill_ppn;
      present[fill_tgt]   <= fill_present;
      kperm_q[fill_tgt]   <= fill_kperm;
      uperm_q[fill_tgt]   <= fill_uperm;
      cacheable[fill_tgt] <= fill_cache;
    end
  end

  // occupancy and status flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used  <= '0;
      refd  <= '0;
      dirty <= '0;
    end else if (flush_all) begin
      used <= '0;
    end else if (inval_en) begin
      if (im_found) used[im_idx] <= 1'b0;
    end else if (fill_go) begin
      used[fill_tgt]  <= 1'b1;
      refd[fill_tgt]  <= 1'b0;
      dirty[fill_tgt] <= 1'b0;
    end else if (lk_go && lk_good) begin
      refd[lk_idx] <= 1'b1;
      if (req_write) dirty[lk_idx] <= 1'b1;
    end
  end

  // response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_pfault <= 1'b0;
      rsp_afault <= 1'b0;
      rsp_ppn    <= '0;
      rsp_cache  <= 1'b0;
      rsp_ref    <= 1'b0;
      rsp_dirty  <= 1'b0;
    end else begin
      rsp_valid  <= lk_go;
      rsp_hit    <= lk_go && lk_good;
      rsp_miss   <= lk_go && !lk_found;
      rsp_pfault <= lk_go && lk_found && !present[lk_idx];
      rsp_afault <= lk_go && lk_found && present[lk_idx] && !lk_ok;
      rsp_ppn    <= ppn_q[lk_idx];
      rsp_cache  <= cacheable[lk_idx];
      rsp_ref    <= lk_found && (refd[lk_idx] || lk_good);
      rsp_dirty  <= lk_found && (dirty[lk_idx] || (lk_good && req_write));
    end
  end

  // R12
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_pfault, rsp_afault}) == 1);

  // R11
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !fill_valid && !flush_all && !inval_en));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush_all) |-> (used == '0));
endmodule

// File: tb/ptlb_top_test.sv
module ptlb_top_test;
  localparam int N = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  cur_pid = 8'd5;
  logic        flush_all = 0, inval_en = 0;
  logic [19:0] inval_vpn = '0;
  logic [7:0]  inval_pid = '0;
  logic        req_valid = 0, req_write = 0, req_user = 0;
  logic [19:0] req_vpn = '0;
  logic        req_ready;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_pfault, rsp_afault, rsp_cache, rsp_ref, rsp_dirty;
  logic [19:0] rsp_ppn;
  logic        fill_valid = 0, fill_ready, fill_present = 0, fill_cache = 0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [7:0]  fill_pid = '0;
  logic [1:0]  fill_kperm = '0, fill_uperm = '0;

  int checks = 0, failures = 0;

  // reference state
  bit         m_used[N];
  bit [19:0]  m_vpn[N];
  bit [7:0]   m_pid[N];
  bit [19:0]  m_ppn[N];
  bit         m_pres[N], m_cache[N], m_ref[N], m_dirty[N];
  bit [1:0]   m_kp[N], m_up[N];
  bit         m_tree[N];

  always #10 clk = ~clk;

  ptlb_top uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void m_touch(input int idx);
    int node = 1;
    for (int l = 3; l >= 0; l--) begin
      int b = (idx >> l) & 1;
      m_tree[node] = (b == 0);
      node = node * 2 + b;
    end
  endfunction

  function automatic int m_victim();
    int node = 1;
    for (int l = 0; l < 4; l++) node = node * 2 + int'(m_tree[node]);
    return node - N;
  endfunction

  function automatic int m_find(input bit [19:0] v, input bit [7:0] p);
    for (int i = 0; i < N; i++) if (m_used[i] && m_vpn[i] == v && m_pid[i] == p) return i;
    return -1;
  endfunction

  task automatic lookup(input bit [19:0] v, input bit user, input bit wr);
    int mi;
    bit [1:0] perm;
    bit ok;
    logic [3:0] exp;
    mi = m_find(v, cur_pid);
    if (mi < 0) exp = 4'b0100;
    else if (!m_pres[mi]) exp = 4'b0010;
    else begin
      perm = user ? m_up[mi] : m_kp[mi];
      ok = (perm != 2'b00) && (!wr || perm[1]);
      exp = ok ? 4'b1000 : 4'b0001;
    end
    @(negedge clk);
    req_vpn = v; req_user = user; req_write = wr; req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R11 rsp_valid", rsp_valid, 1);
    case (exp)
      4'b1000: chk("R1/R4 outcome hit", {rsp_hit, rsp_miss, rsp_pfault, rsp_afault}, exp);
      4'b0100: chk("R2 outcome miss", {rsp_hit, rsp_miss, rsp_pfault, rsp_afault}, exp);
      4'b0010: chk("R3 outcome pfault", {rsp_hit, rsp_miss, rsp_pfault, rsp_afault}, exp);
      default: chk("R4 outcome afault", {rsp_hit, rsp_miss, rsp_pfault, rsp_afault}, exp);
    endcase
    if (exp == 4'b1000) begin
      m_ref[mi] = 1;
      if (wr) m_dirty[mi] = 1;
      m_touch(mi);
      chk("R1 ppn", rsp_ppn, m_ppn[mi]);
      chk("R1 cache", rsp_cache, m_cache[mi]);
      chk("R5 ref", rsp_ref, m_ref[mi]);
      chk("R5 dirty", rsp_dirty, m_dirty[mi]);
    end
  endtask

  task automatic fill(input bit [19:0] v, input bit [7:0] p, input bit [19:0] pp,
                      input bit pres, input bit [1:0] kp, input bit [1:0] up, input bit c);
    int t;
    t = m_find(v, p);
    if (t < 0) begin
      for (int i = N - 1; i >= 0; i--) if (!m_used[i]) t = i;
      if (t < 0) t = m_victim();
    end
    m_used[t] = 1; m_vpn[t] = v; m_pid[t] = p; m_ppn[t] = pp; m_pres[t] = pres;
    m_kp[t] = kp; m_up[t] = up; m_cache[t] = c; m_ref[t] = 0; m_dirty[t] = 0;
    m_touch(t);
    @(negedge clk);
    fill_vpn = v; fill_pid = p; fill_ppn = pp; fill_present = pres;
    fill_kperm = kp; fill_uperm = up; fill_cache = c; fill_valid = 1;
    #1 chk("R11 fill_ready", fill_ready, 1);
    @(posedge clk);
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic inval(input bit [19:0] v, input bit [7:0] p);
    int t;
    t = m_find(v, p);
    if (t >= 0) m_used[t] = 0;
    @(negedge clk);
    inval_vpn = v; inval_pid = p; inval_en = 1;
    @(posedge clk);
    @(negedge clk);
    inval_en = 0;
  endtask

  task automatic sweep(input bit [7:0] p);
    cur_pid = p;
    for (int i = 0; i < 20; i++) lookup(20'h100 + 20'(i), 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL R11 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_used[i] = 0; m_tree[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R11 reset rsp_valid", rsp_valid, 0);
    chk("R11 reset req_ready", req_ready, 1);
    chk("R11 reset fill_ready", fill_ready, 1);
    lookup(20'h100, 0, 0);                       // R2 empty buffer

    // fill all slots, varied permissions
    for (int i = 0; i < N; i++)
      fill(20'h100 + 20'(i), 8'd5, 20'h5000 + 20'(7 * i), (i % 5) != 3,
           2'(i % 4), 2'((i / 4) % 4), bit'(i % 2));
    // R1 R3 R4 R5: every slot under every mode
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < N; i++) lookup(20'h100 + 20'(i), bit'(m >> 1), bit'(m & 1));

    // R10 context switch
    cur_pid = 8'd6;
    lookup(20'h101, 0, 0);
    cur_pid = 8'd5;
    lookup(20'h101, 0, 0);

    // R7 evictions with full buffer
    for (int k = 0; k < 3; k++) begin
      fill(20'h100 + 20'(k), 8'd6, 20'h7700 + 20'(k), 1, 2'b10, 2'b01, 1);
      sweep(8'd5);
      sweep(8'd6);
    end

    // R6 refill of resident key
    fill(20'h10A, 8'd5, 20'hABCDE, 1, 2'b10, 2'b10, 0);
    sweep(8'd5);

    // R8 single invalidation, wrong-tag invalidation ignored
    inval(20'h10C, 8'd5);
    inval(20'h10D, 8'd9);
    sweep(8'd5);

    // R11 priority, no clock edge consumed
    @(negedge clk);
    fill_valid = 1; req_valid = 1;
    #1 chk("R11 fill blocks lookup", req_ready, 0);
    chk("R11 fill accepted", fill_ready, 1);
    flush_all = 1;
    #1 chk("R11 flush blocks fill", fill_ready, 0);
    flush_all = 0; inval_en = 1;
    #1 chk("R11 inval blocks fill", fill_ready, 0);
    inval_en = 0; fill_valid = 0; req_valid = 0;

    // R9 flush all
    for (int i = 0; i < N; i++) m_used[i] = 0;
    @(negedge clk);
    flush_all = 1;
    @(posedge clk);
    @(negedge clk);
    flush_all = 0;
    sweep(8'd5);
    sweep(8'd6);
    fill(20'h222, 8'd5, 20'h12345, 1, 2'b01, 2'b00, 1);
    cur_pid = 8'd5;
    lookup(20'h222, 0, 0);
    lookup(20'h222, 0, 1);
    lookup(20'h222, 1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule